// File: doc/BRIEF.md
# Programming bus frame decoder

This block passively watches the four lines of a serial programming port: a slow bit clock, a data line, the target's supply rail and a mode-select line. A transaction lasts while mode-select and supply are both high. During it, every rising edge of the bit clock captures one data bit. The first 48 bits form a header: a fixed 28-bit sync pattern (0xA5A5A5A), an 8-bit command code and a fixed 12-bit end marker (0xAA1). Bits arrive most significant first.

Once the header checks out, the block emits the command as a record. For the write codes (0x70, 0x71) and the read code (0x60), the bits that follow are cut into 14-bit words and emitted one record each. All of the port lines are asynchronous to the system clock, so each one passes through a synchronizer first. Edges are then detected in the system-clock domain.

Records leave on a registered stream: a one-cycle valid strobe, a 2-bit kind tag and a 14-bit value. A logger or a trace buffer is the expected consumer. Malformed headers and transactions that are cut short produce error records.

Top module: `pbd_monitor`

## Requirements
- R1: While reset is high, and in the cycle after it, `rec_valid_o` is low.
- R2: Bit-clock edges are ignored unless mode-select and supply are both high. Such edges add no bits, produce no records and do not disturb the next transaction.
- R3: If the first 28 header bits differ from 0xA5A5A5A, one record of kind 3 (error) with value 1 is emitted. No command record is emitted.
- R4: If the sync pattern matches but header bits 36 to 47 differ from 0xAA1, one error record with value 2 is emitted.
- R5: A valid header emits one record of kind 0 (command). Its value is header bits 28 to 35 (bit 28 is the MSB), zero-extended to 14 bits.
- R6: After command 0x70 or 0x71, each 14-bit word (MSB first) is emitted as it completes. The words repeat in groups of five: the first four have kind 1 (data) and the fifth has kind 2 (address).
- R7: After command 0x60, every 14-bit word is emitted with kind 1.
- R8: After any other valid command, later bits produce no records.
- R9: If the transaction ends while the header or a payload word is incomplete (1 or more bits held), one error record with value 3 is emitted. A transaction that ends on a word boundary adds no error.
- R10: Every record is a single-cycle strobe, and two records are never in adjacent cycles.
- R11: After a bad header (R3, R4), the rest of the transaction is ignored, including a partial word at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_clk_i | input | 1 | Programming bit clock (asynchronous) |
| prog_dat_i | input | 1 | Programming data line (asynchronous) |
| prog_vdd_i | input | 1 | Target supply state, high = on (asynchronous) |
| prog_mode_i | input | 1 | Mode-select line (asynchronous) |
| rec_valid_o | output | 1 | One-cycle record strobe |
| rec_kind_o | output | 2 | 0 command, 1 data, 2 address, 3 error |
| rec_data_o | output | 14 | Command code, word value or error code |

## Verification
On every cycle, the assertions check the shape of the output stream: quiet through reset, single-cycle strobes, command values that fit in 8 bits, and error values drawn only from the three defined codes. Which records appear, in what order, with what tags and values, depends on whole serial transactions. Only the bench scenarios can show that. These cover header corruption, truncation at any bit, write groups that wrap into a second address, and clock activity while the port is unpowered.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_DATA = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_ERR  = 2'd3
  } rec_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_PAY,
    PH_SKIP
  } phase_e;

  localparam int ERR_SYNC = 1;
  localparam int ERR_END  = 2;
  localparam int ERR_CUT  = 3;
endpackage

// File: rtl/pbd_sync.sv
module pbd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pbd_events.sv
module pbd_events (
  input  logic clk,
  input  logic rst,
  input  logic pclk_s,
  input  logic act_s,
  output logic bit_stb,
  output logic act_rise,
  output logic act_fall
);
  logic pclk_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pclk_q <= pclk_s;
      act_q  <= act_s;
    end
  end

  assign bit_stb  = pclk_s & ~pclk_q & act_s & act_q;
  assign act_rise = act_s & ~act_q;
  assign act_fall = ~act_s & act_q;
endmodule

// File: rtl/pbd_deframer.sv
module pbd_deframer
  import pbd_pkg::*;
#(
  parameter int HDR_BITS    = 48,
  parameter int PRE_BITS    = 28,
  parameter int TRL_BITS    = 12,
  parameter logic [PRE_BITS-1:0] SYNC_PAT = 28'hA5A5A5A,
  parameter logic [TRL_BITS-1:0] END_PAT  = 12'hAA1,
  parameter int WORD_W      = 14,
  parameter int GROUP_WORDS = 4,
  parameter logic [7:0] CMD_WR_A = 8'h70,
  parameter logic [7:0] CMD_WR_B = 8'h71,
  parameter logic [7:0] CMD_RD   = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              act_rise,
  input  logic              act_fall,
  output logic              emit,
  output rec_kind_e         emit_kind,
  output logic [WORD_W-1:0] emit_data
);
  localparam int CMD_W = HDR_BITS - PRE_BITS - TRL_BITS;
  localparam int CNT_W = $clog2(HDR_BITS + 1);
  localparam int GRP_W = $clog2(GROUP_WORDS + 1);

  phase_e              ph_q, ph_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-1:0] sh_q, sh_d;
  logic [GRP_W-1:0]    grp_q, grp_d;
  logic                wr_q, wr_d;

  logic [HDR_BITS-1:0] frame;
  logic [CMD_W-1:0]    cmd;

  assign frame = {sh_q[HDR_BITS-2:0], bit_val};
  assign cmd   = frame[TRL_BITS +: CMD_W];

  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    grp_d     = grp_q;
    wr_d      = wr_q;
    emit      = 1'b0;
    emit_kind = KIND_CMD;
    emit_data = '0;
    if (act_rise) begin
      ph_d  = PH_HDR;
      cnt_d = '0;
      grp_d = '0;
      wr_d  = 1'b0;
    end else if (act_fall) begin
      if ((ph_q == PH_HDR || ph_q == PH_PAY) && cnt_q != '0) begin
        emit      = 1'b1;
        emit_kind = KIND_ERR;
        emit_data = WORD_W'(ERR_CUT);
      end
      ph_d = PH_IDLE;
    end else if (bit_stb) begin
      case (ph_q)
        PH_HDR: begin
          sh_d  = frame;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            cnt_d = '0;
            emit  = 1'b1;
            if (frame[HDR_BITS-1 -: PRE_BITS] != SYNC_PAT) begin
              emit_kind = KIND_ERR;
              emit_data = WORD_W'(ERR_SYNC);
              ph_d      = PH_SKIP;
            end else if (frame[TRL_BITS-1:0] != END_PAT) begin
              emit_kind = KIND_ERR;
              emit_data = WORD_W'(ERR_END);
              ph_d      = PH_SKIP;
            end else begin
              emit_kind              = KIND_CMD;
              emit_data[CMD_W-1:0]   = cmd;
              wr_d = (cmd == CMD_WR_A) || (cmd == CMD_WR_B);
              ph_d = (wr_d || cmd == CMD_RD) ? PH_PAY : PH_SKIP;
            end
          end
        end
        PH_PAY: begin
          sh_d  = frame;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            cnt_d     = '0;
            emit      = 1'b1;
            emit_data = frame[WORD_W-1:0];
            emit_kind = (wr_q && grp_q == GRP_W'(GROUP_WORDS)) ? KIND_ADDR : KIND_DATA;
            grp_d     = (grp_q == GRP_W'(GROUP_WORDS)) ? '0 : grp_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      grp_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      grp_q <= grp_d;
      wr_q  <= wr_d;
    end
  end
endmodule

// File: rtl/pbd_monitor.sv
module pbd_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 14,
  parameter int GROUP_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_clk_i,
  input  logic              prog_dat_i,
  input  logic              prog_vdd_i,
  input  logic              prog_mode_i,
  output logic              rec_valid_o,
  output logic [1:0]        rec_kind_o,
  output logic [WORD_W-1:0] rec_data_o
);
  import pbd_pkg::*;

  logic [3:0]        pins_s;
  logic              bit_stb, act_rise, act_fall, emit;
  rec_kind_e         emit_kind;
  logic [WORD_W-1:0] emit_data;

  pbd_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({prog_mode_i, prog_vdd_i, prog_clk_i, prog_dat_i}),
    .q_o (pins_s)
  );

  pbd_events u_events (
    .clk      (clk),
    .rst      (rst),
    .pclk_s   (pins_s[1]),
    .act_s    (pins_s[3] & pins_s[2]),
    .bit_stb  (bit_stb),
    .act_rise (act_rise),
    .act_fall (act_fall)
  );

  pbd_deframer #(.WORD_W(WORD_W), .GROUP_WORDS(GROUP_WORDS)) u_deframer (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .bit_val   (pins_s[0]),
    .act_rise  (act_rise),
    .act_fall  (act_fall),
    .emit      (emit),
    .emit_kind (emit_kind),
    .emit_data (emit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid_o <= 1'b0;
      rec_kind_o  <= 2'd0;
      rec_data_o  <= '0;
    end else begin
      rec_valid_o <= emit;
      if (emit) begin
        rec_kind_o <= emit_kind;
        rec_data_o <= emit_data;
      end
    end
  end
endmodule

// File: rtl/pbd_monitor_chk.sv
module pbd_monitor_chk #(
  parameter int WORD_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              rec_valid_o,
  input logic [1:0]        rec_kind_o,
  input logic [WORD_W-1:0] rec_data_o
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !rec_valid_o);

  assert_cmd_fits_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && rec_kind_o == 2'd0) |-> (rec_data_o[WORD_W-1:8] == '0));

  assert_err_code_R9: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && rec_kind_o == 2'd3) |-> (rec_data_o >= 1 && rec_data_o <= 3));

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o |=> !rec_valid_o);
endmodule

bind pbd_monitor pbd_monitor_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rec_valid_o (rec_valid_o),
  .rec_kind_o  (rec_kind_o),
  .rec_data_o  (rec_data_o)
);

// File: tb/pbd_monitor_tb.sv
module pbd_monitor_tb;
  localparam int HALF = 4;
  localparam logic [27:0] SYNC = 28'hA5A5A5A;
  localparam logic [11:0] ENDM = 12'hAA1;

  logic clk = 1'b0, rst = 1'b1;
  logic pclk = 1'b0, pdat = 1'b0, pvdd = 1'b0, pmode = 1'b0;
  logic rec_valid;
  logic [1:0] rec_kind;
  logic [13:0] rec_data;

  int tests = 0, fails = 0;
  int gn = 0, en = 0, back2back = 0;
  int gk [64], gd [64], ek [64], ed [64];
  logic prev_valid = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  pbd_monitor u_dut (
    .clk (clk), .rst (rst),
    .prog_clk_i (pclk), .prog_dat_i (pdat),
    .prog_vdd_i (pvdd), .prog_mode_i (pmode),
    .rec_valid_o (rec_valid), .rec_kind_o (rec_kind), .rec_data_o (rec_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rec_valid && prev_valid) back2back++;
      if (rec_valid && gn < 64) begin
        gk[gn] = int'(rec_kind);
        gd[gn] = int'(rec_data);
        gn++;
      end
      prev_valid = rec_valid;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    pdat = b;
    wait_cyc(HALF);
    pclk = 1'b1;
    wait_cyc(HALF);
    pclk = 1'b0;
  endtask

  task automatic push_exp(int k, int d);
    ek[en] = k;
    ed[en] = d;
    en++;
  endtask

  task automatic compare(string req);
    check(gn == en, req, "record count", gn, en);
    for (int i = 0; i < en && i < gn; i++) begin
      check(gk[i] == ek[i], (ek[i] == 0) ? "R5" : req, "record kind", gk[i], ek[i]);
      check(gd[i] == ed[i], (ek[i] == 0) ? "R5" : req, "record value", gd[i], ed[i]);
    end
  endtask

  // hdr_n: header bits sent (48 = full); nwords full payload words; extra: partial bits
  task automatic run_txn(logic [7:0] cmd, bit bad_sync, bit bad_end, int hdr_n,
                         int nwords, int extra, string req);
    logic [27:0] s = SYNC;
    logic [11:0] e = ENDM;
    logic [47:0] fr;
    bit good, wr, pay;
    int w;
    if (bad_sync) s = s ^ (28'h1 << ($urandom % 28));
    if (bad_end)  e = e ^ (12'h1 << ($urandom % 12));
    fr = {s, cmd, e};
    good = !bad_sync && !bad_end;
    wr   = (cmd == 8'h70) || (cmd == 8'h71);
    pay  = wr || (cmd == 8'h60);
    gn = 0; en = 0;
    pmode = 1'b1; wait_cyc(6);
    pvdd  = 1'b1; wait_cyc(8);
    for (int i = 0; i < hdr_n; i++) send_bit(fr[47-i]);
    if (hdr_n < 48) begin
      if (hdr_n > 0) push_exp(3, 3);
    end else begin
      if (bad_sync) push_exp(3, 1);
      else if (bad_end) push_exp(3, 2);
      else push_exp(0, int'(cmd));
      for (int k = 0; k < nwords; k++) begin
        w = int'($urandom % 16384);
        for (int b = 13; b >= 0; b--) send_bit(w[b]);
        if (good && pay) push_exp((wr && (k % 5) == 4) ? 2 : 1, w);
      end
      for (int b = 0; b < extra; b++) send_bit(1'($urandom));
      if (good && pay && extra > 0) push_exp(3, 3);
    end
    wait_cyc(6);
    pvdd = 1'b0; wait_cyc(6);
    pmode = 1'b0; wait_cyc(12);
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wait_cyc(5);
    check(rec_valid == 1'b0, "R1", "valid during reset", int'(rec_valid), 0);
    rst = 1'b0;
    wait_cyc(2);
    check(rec_valid == 1'b0, "R1", "valid after reset", int'(rec_valid), 0);

    // R2: clock activity while unpowered or mode low must be ignored
    gn = 0;
    pmode = 1'b1;
    for (int i = 0; i < 30; i++) send_bit(1'($urandom));
    pmode = 1'b0; pvdd = 1'b1;
    for (int i = 0; i < 30; i++) send_bit(1'($urandom));
    pvdd = 1'b0; wait_cyc(10);
    check(gn == 0, "R2", "records while inactive", gn, 0);
    run_txn(8'h61, 0, 0, 48, 0, 0, "R2");

    run_txn(8'h61, 0, 0, 48, 2, 5, "R8");
    run_txn(8'h31, 0, 0, 48, 0, 0, "R8");
    run_txn(8'h70, 0, 0, 48, 10, 0, "R6");
    run_txn(8'h71, 0, 0, 48, 6, 0, "R6");
    run_txn(8'h60, 0, 0, 48, 3, 0, "R7");
    run_txn(8'h70, 1, 0, 48, 3, 7, "R3");
    run_txn(8'h60, 0, 1, 48, 2, 3, "R4");
    run_txn(8'h71, 1, 1, 48, 1, 0, "R11");
    run_txn(8'h70, 0, 0, 20, 0, 0, "R9");
    run_txn(8'h70, 0, 0, 47, 0, 0, "R9");
    run_txn(8'h70, 0, 0, 48, 2, 5, "R9");
    run_txn(8'h60, 0, 0, 48, 1, 13, "R9");

    for (int t = 0; t < 30; t++) begin
      logic [7:0] c;
      int sel = int'($urandom % 6);
      bit bs = ($urandom % 6) == 0;
      bit be = ($urandom % 6) == 0;
      int hn = (($urandom % 8) == 0) ? int'($urandom % 48) : 48;
      int nw = int'($urandom % 11);
      int ex = (($urandom % 3) == 0) ? int'(1 + $urandom % 13) : 0;
      string rq;
      c = (sel == 0) ? 8'h70 : (sel == 1) ? 8'h71 : (sel == 2) ? 8'h60 :
          (sel == 3) ? 8'h61 : (sel == 4) ? 8'h66 : 8'($urandom);
      if (hn < 48) rq = "R9";
      else if (bs) rq = "R3";
      else if (be) rq = "R4";
      else if (c == 8'h70 || c == 8'h71) rq = "R6";
      else if (c == 8'h60) rq = "R7";
      else rq = "R8";
      run_txn(c, bs, be, hn, nw, ex, rq);
    end

    check(back2back == 0, "R10", "adjacent strobes", back2back, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule